// File: doc/BRIEF.md
# Saturating Biquad Harmonic Notch

This block is one second-order recursive section in canonical direct-form II arrangement. Its job is to cut a single harmonic of a 50 Hz fundamental out of a sampled waveform. The numerator is 1, -2cos(w), 1, which puts the zeros on the unit circle. The denominator is 1, -2·rho·cos(w), rho², and with rho near 0.95 it sets the width of the notch. The coefficients are worked out offline and loaded through a small write port.

Each input sample is a signed 16-bit value with a strobe, and each one produces exactly one signed 16-bit result. Two state registers carry the two previous intermediate values. The new intermediate value is clamped before it is stored, so an overflow cannot wrap and throw the recursion off. To suppress several harmonics, such as 150, 250 and 350 Hz, chain several instances output to input.

Top module: `notch_biquad`

## Requirements
- R1: After reset, out_valid_o and out_data_o are 0, the state is zero, and the coefficients are b0 = 1.0 (0x10000) and b1 = b2 = a1 = a2 = 0. In that state every sample comes out unchanged.
- R2: out_valid_o is high exactly two clock cycles after each cycle in which in_valid_i is high, and it is low otherwise.
- R3: Samples are Q1.15 and coefficients are Q2.16 two's complement. On each accepted sample the block computes w0 = floor((x·2^17 − a1·w1 − a2·w2) / 2^16), where w1 and w2 are the stored states at 16 fractional bits. The minus sign on the feedback is applied inside the block. The states then advance: w2 takes w1, and w1 takes w0.
- R4: The output is y = floor((b0·w0 + b1·w1 + b2·w2 + 2^16) / 2^17), which rounds half up to Q1.15. w1 and w2 here are the states before the update. out_data_o holds its value between valid outputs.
- R5: The state advances only on accepted samples. Idle cycles leave it unchanged.
- R6: w0 saturates to the signed 24-bit limits, +8388607 and −8388608, before it is used or stored.
- R7: The output saturates to +32767 and −32768.
- R8: A clear_i pulse sets w1 and w2 to zero. The coefficients keep their values.
- R9: A write with cfg_addr_i 0..4 loads b0, b1, b2, a1 or a2 respectively, and it also sets w1 and w2 to zero. A write to addresses 5..7 changes neither the coefficients nor the state.
- R10: When loaded with notch coefficients for 150 Hz at an 8 kHz sample rate with rho = 0.95, a steady 150 Hz tone of amplitude 10000 settles to a residual below 400. A 1 kHz tone still comes through with a peak above 8500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Zero the two state registers |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 3 | Coefficient select: 0 b0, 1 b1, 2 b2, 3 a1, 4 a2 |
| cfg_data_i | input | 18 | Coefficient value, signed Q2.16 |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Input sample, signed Q1.15 |
| out_valid_o | output | 1 | Output strobe, two cycles after the input strobe |
| out_data_o | output | 16 | Output sample, signed Q1.15 |

## Verification
The bench keeps a bit-exact model of the recursion. With it the bench finds any feedback sign error, a shift taken by the wrong amount, or a rounding offset that is off by one. Any of these makes the outputs drift apart within a few samples. Idle gaps between samples are there to catch a state that also advances on empty cycles; such a state would shift the output history. Runaway feedback and large gains push the intermediate value and the output to their limits. A design that wrapped instead of clamping would jump sign at that point instead of holding the rail. Clear pulses and writes, including writes to unmapped addresses, check that state is dropped only when it should be. A design that kept stale state would show a tail of echoes, and one that decoded the address wrongly would corrupt a coefficient.

// File: rtl/notch_pkg.sv
package notch_pkg;
  localparam int DATA_W    = 16;
  localparam int COEF_W    = 18;
  localparam int COEF_FRAC = 16;
  localparam int STATE_W   = 24;
  localparam int NUM_COEF  = 5;
  localparam int ADDR_W    = 3;
  // shift between sample scale (DATA_W-1 frac) and product scale (2*COEF_FRAC frac)
  localparam int ALIGN_SH  = 2 * COEF_FRAC - (DATA_W - 1);
  localparam int ACC_W     = COEF_W + STATE_W + 2;

  typedef enum logic [ADDR_W-1:0] {
    CO_B0 = 3'd0, CO_B1 = 3'd1, CO_B2 = 3'd2, CO_A1 = 3'd3, CO_A2 = 3'd4
  } coef_idx_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] b2;
    logic signed [COEF_W-1:0] a1;
    logic signed [COEF_W-1:0] a2;
  } coef_set_t;
endpackage

// File: rtl/notch_coef_bank.sv
module notch_coef_bank
  import notch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COEF_W-1:0] wdata_i,
  output coef_set_t         coefs_o,
  output logic              changed_o
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(longint'(1) <<< COEF_FRAC);

  logic [COEF_W-1:0] regs_q [NUM_COEF];

  for (genvar g = 0; g < NUM_COEF; g++) begin : g_coef
    localparam logic [COEF_W-1:0] RST_VAL = (g == int'(CO_B0)) ? UNITY : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= RST_VAL;
      else if (we_i && (addr_i == ADDR_W'(g)))      regs_q[g] <= wdata_i;
    end
  end

  assign coefs_o.b0 = regs_q[CO_B0];
  assign coefs_o.b1 = regs_q[CO_B1];
  assign coefs_o.b2 = regs_q[CO_B2];
  assign coefs_o.a1 = regs_q[CO_A1];
  assign coefs_o.a2 = regs_q[CO_A2];

  assign changed_o = we_i && (addr_i < ADDR_W'(NUM_COEF));

  // R9: unmapped writes leave the bank untouched
  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i >= ADDR_W'(NUM_COEF))) |=> $stable(coefs_o));
endmodule

// File: rtl/notch_state_stage.sv
module notch_state_stage
  import notch_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic signed [DATA_W-1:0]  x_i,
  input  logic                      clear_i,
  input  logic signed [COEF_W-1:0]  a1_i,
  input  logic signed [COEF_W-1:0]  a2_i,
  output logic                      valid_o,
  output logic signed [STATE_W-1:0] w0_o,
  output logic signed [STATE_W-1:0] w1_o,
  output logic signed [STATE_W-1:0] w2_o
);
  localparam logic signed [ACC_W-1:0] W_MAX = ACC_W'((longint'(1) <<< (STATE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] W_MIN = ACC_W'(-(longint'(1) <<< (STATE_W - 1)));

  logic signed [STATE_W-1:0] w1_q, w2_q, w0;
  logic signed [ACC_W-1:0]   x_ext, a1_ext, a2_ext, w1_ext, w2_ext;
  logic signed [ACC_W-1:0]   acc, acc_sh, acc_sat;

  always_comb begin
    x_ext   = ACC_W'(x_i);
    a1_ext  = ACC_W'(a1_i);
    a2_ext  = ACC_W'(a2_i);
    w1_ext  = ACC_W'(w1_q);
    w2_ext  = ACC_W'(w2_q);
    // feedback sign applied here: registers hold denominator terms as written
    acc     = (x_ext <<< ALIGN_SH) - a1_ext * w1_ext - a2_ext * w2_ext;
    acc_sh  = acc >>> COEF_FRAC;
    if (acc_sh > W_MAX)      acc_sat = W_MAX;
    else if (acc_sh < W_MIN) acc_sat = W_MIN;
    else                     acc_sat = acc_sh;
    w0      = STATE_W'(acc_sat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      w0_o    <= '0;
      w1_o    <= '0;
      w2_o    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) begin
        w0_o <= w0;
        w1_o <= w1_q;
        w2_o <= w2_q;
      end
      if (clear_i) begin
        w1_q <= '0;
        w2_q <= '0;
      end else if (in_valid_i) begin
        w1_q <= w0;
        w2_q <= w1_q;
      end
    end
  end

  assert_state_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !clear_i) |=> ($stable(w1_q) && $stable(w2_q)));

  assert_state_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !clear_i) |=> (w2_q == $past(w1_q)));

  // R8 and R9: clear and coefficient change both arrive on clear_i
  assert_state_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((w1_q == '0) && (w2_q == '0)));
endmodule

// File: rtl/notch_output_stage.sv
module notch_output_stage
  import notch_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [STATE_W-1:0] w0_i,
  input  logic signed [STATE_W-1:0] w1_i,
  input  logic signed [STATE_W-1:0] w2_i,
  input  logic signed [COEF_W-1:0]  b0_i,
  input  logic signed [COEF_W-1:0]  b1_i,
  input  logic signed [COEF_W-1:0]  b2_i,
  output logic                      valid_o,
  output logic signed [DATA_W-1:0]  y_o
);
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((longint'(1) <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = ACC_W'(-(longint'(1) <<< (DATA_W - 1)));
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(longint'(1) <<< (ALIGN_SH - 1));

  logic signed [ACC_W-1:0] acc, acc_sh, acc_sat;
  logic signed [DATA_W-1:0] y_d;

  always_comb begin
    acc = ACC_W'(b0_i) * ACC_W'(w0_i)
        + ACC_W'(b1_i) * ACC_W'(w1_i)
        + ACC_W'(b2_i) * ACC_W'(w2_i)
        + HALF;
    acc_sh = acc >>> ALIGN_SH;
    if (acc_sh > Y_MAX)      acc_sat = Y_MAX;
    else if (acc_sh < Y_MIN) acc_sat = Y_MIN;
    else                     acc_sat = acc_sh;
    y_d = DATA_W'(acc_sat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) y_o <= y_d;
    end
  end

  assert_out_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));
endmodule

// File: rtl/notch_biquad.sv
module notch_biquad
  import notch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [17:0]       cfg_data_i,
  input  logic              in_valid_i,
  input  logic [15:0]       in_data_i,
  output logic              out_valid_o,
  output logic [15:0]       out_data_o
);
  coef_set_t                 coefs;
  logic                      coef_changed;
  logic                      state_clear;
  logic                      s1_valid;
  logic signed [STATE_W-1:0] s1_w0, s1_w1, s1_w2;
  logic signed [DATA_W-1:0]  y;

  notch_coef_bank u_coef (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_data_i),
    .coefs_o   (coefs),
    .changed_o (coef_changed)
  );

  assign state_clear = clear_i | coef_changed;

  notch_state_stage u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .x_i        (in_data_i),
    .clear_i    (state_clear),
    .a1_i       (coefs.a1),
    .a2_i       (coefs.a2),
    .valid_o    (s1_valid),
    .w0_o       (s1_w0),
    .w1_o       (s1_w1),
    .w2_o       (s1_w2)
  );

  notch_output_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .w0_i    (s1_w0),
    .w1_i    (s1_w1),
    .w2_i    (s1_w2),
    .b0_i    (coefs.b0),
    .b1_i    (coefs.b1),
    .b2_i    (coefs.b2),
    .valid_o (out_valid_o),
    .y_o     (y)
  );

  assign out_data_o = y;

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);
endmodule

// File: tb/notch_biquad_tb_top.sv
`timescale 1ns/1ps
module notch_biquad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [17:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  notch_biquad dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  // reference model state
  longint m_c[5];
  longint m_w1, m_w2;
  longint exp_q[$];
  string  cur_req = "R1";
  bit     track = 1'b0;
  longint peak = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint clamp(input longint v, input longint lo, input longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // R3/R4/R6/R7 model
  function automatic longint model_step(input longint x);
    longint w0, acc, y;
    acc = (x <<< 17) - m_c[3] * m_w1 - m_c[4] * m_w2;
    w0  = clamp(acc >>> 16, -8388608, 8388607);
    y   = (m_c[0] * w0 + m_c[1] * m_w1 + m_c[2] * m_w2 + 65536) >>> 17;
    y   = clamp(y, -32768, 32767);
    m_w2 = m_w1;
    m_w1 = w0;
    return y;
  endfunction

  always @(negedge clk) begin
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, longint'($signed(out_data)), 0);
      end else begin
        longint e;
        e = exp_q.pop_front();
        check(longint'($signed(out_data)) == e, cur_req, longint'($signed(out_data)), e);
      end
      if (track) begin
        longint a;
        a = longint'($signed(out_data));
        if (a < 0) a = -a;
        if (a > peak) peak = a;
      end
    end
  end

  task automatic send(input longint x);
    in_data  = 16'(x);
    in_valid = 1'b1;
    exp_q.push_back(model_step(x));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_coef(input int addr, input longint val);
    cfg_we   = 1'b1;
    cfg_addr = 3'(addr);
    cfg_data = 18'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 5) begin
      m_c[addr] = val;
      m_w1 = 0;
      m_w2 = 0;
    end
  endtask

  task automatic drain();
    idle(4);
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == 16'd0, "R1", out_data, 0);
  endtask

  task automatic t_identity();
    cur_req = "R1";
    send(1234); send(-32768); send(32767); send(-1); send(0);
    drain();
  endtask

  task automatic t_latency();
    cur_req = "R2";
    in_data = 16'd77; in_valid = 1'b1;
    exp_q.push_back(model_step(77));
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", out_valid, 0);
    drain();
  endtask

  task automatic t_recursion();
    cur_req = "R3";
    write_coef(0, 40000); write_coef(1, -70000); write_coef(2, 52000);
    write_coef(3, -90000); write_coef(4, 50000);
    for (int i = 0; i < 60; i++) send(longint'($signed(16'($urandom_range(0, 65535)))) / 4);
    drain();
    cur_req = "R4";
    for (int i = 0; i < 20; i++) send((i % 2 == 0) ? 12345 : -12001);
    drain();
  endtask

  task automatic t_idle_gaps();
    cur_req = "R5";
    for (int i = 0; i < 30; i++) begin
      send(longint'(i * 700 - 9000));
      idle(i % 4);
    end
    drain();
  endtask

  task automatic t_w0_sat();
    cur_req = "R6";
    write_coef(0, 16); write_coef(1, 0); write_coef(2, 0);
    write_coef(3, -131072); write_coef(4, 0);
    for (int i = 0; i < 12; i++) send(32767);
    drain();
    check(m_w1 == 8388607, "R6", m_w1, 8388607);
    send(32767);
    drain();
    write_coef(3, -131072);
    for (int i = 0; i < 12; i++) send(-32768);
    drain();
  endtask

  task automatic t_out_sat();
    cur_req = "R7";
    write_coef(0, 131071); write_coef(3, 0); write_coef(4, 0);
    send(30000); send(-30000); send(16000); send(-16500);
    drain();
  endtask

  task automatic t_clear();
    cur_req = "R8";
    write_coef(0, 65536); write_coef(1, 30000); write_coef(2, 20000);
    write_coef(3, -60000); write_coef(4, 40000);
    for (int i = 0; i < 8; i++) send(20000);
    idle(2);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    m_w1 = 0; m_w2 = 0;
    send(0); send(0); send(500);
    drain();
  endtask

  task automatic t_cfg_write();
    cur_req = "R9";
    for (int i = 0; i < 6; i++) send(15000);
    idle(2);
    write_coef(6, 99999);   // ignored: state and coefs persist in model
    write_coef(5, -1);
    send(0); send(0); send(100);
    drain();
    write_coef(2, 20000);   // mapped: state dropped
    send(0); send(0); send(300);
    drain();
  endtask

  task automatic run_tone(input real f, input int n, output longint pk);
    peak = 0; track = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == n - 200) begin idle(3); track = 1'b1; peak = 0; end
      send(longint'($rtoi(10000.0 * $sin(2.0 * 3.141592653589793 * f * i / 8000.0))));
    end
    drain();
    track = 1'b0;
    pk = peak;
  endtask

  task automatic t_notch();
    real c;
    longint pk;
    cur_req = "R10";
    c = $cos(2.0 * 3.141592653589793 * 150.0 / 8000.0);
    write_coef(0, 65536);
    write_coef(1, longint'($rtoi(-2.0 * c * 65536.0)));
    write_coef(2, 65536);
    write_coef(3, longint'($rtoi(-2.0 * 0.95 * c * 65536.0)));
    write_coef(4, longint'($rtoi(0.9025 * 65536.0)));
    run_tone(150.0, 600, pk);
    check(pk < 400, "R10", pk, 400);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    m_w1 = 0; m_w2 = 0;
    run_tone(1000.0, 400, pk);
    check(pk > 8500, "R10", pk, 8500);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
    finish_run();
  end

  initial begin
    m_c[0] = 65536; m_c[1] = 0; m_c[2] = 0; m_c[3] = 0; m_c[4] = 0;
    m_w1 = 0; m_w2 = 0;
    idle(3);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_identity();
    t_latency();
    t_recursion();
    t_idle_gaps();
    t_w0_sat();
    t_out_sat();
    t_clear();
    t_cfg_write();
    t_notch();
    finish_run();
  end
endmodule